// File: doc/BRIEF.md
# Dithered PWM Channel Pair for a Two-Coil Stepper Motor

This block drives one two-coil stepper motor through four H-bridge gate outputs. It has two independent PWM channels. Channel 0 drives the sine coil and channel 1 drives the cosine coil. Each channel holds a shadow copy of its settings: an 11-bit duty word, a sign bit, an alignment mode and a dither enable. A single write port fills the shadow copy. The channel adopts the shadow copy only when its current period ends, so no partial or doubled pulse can appear on a coil. The sign bit decides which side of the H-bridge carries the pulse train. The other side stays low.

Each channel has its own period timer, a two-state machine with the states `T_UP` and `T_DOWN`. In the left and right aligned modes the timer stays in `T_UP` and wraps from the top count back to 0. That wrap ends a period of 2^(W-1) counts. In center mode the timer climbs to the top count, takes the `T_UP -> T_DOWN` transition, and holds the top count for one extra step. It then falls to 0 and takes the `T_DOWN -> T_UP` transition, which ends a period of twice the length. A prescaler enable input `tick` gates every timer step. The upper W-1 duty bits set the active length in counts. When dithering is on, the duty LSB adds one count in every second period, so the average over two periods carries the full 11-bit resolution.

Top module: `stepper_pwm_pair`

## Requirements
- R1: During reset and after it, with no write yet, all four coil outputs are low, and both channels run in left alignment with duty 0.
- R2: Alignment code 0 (left) gives a period of P = 2^(W-1) cycles when `tick` is held high. The active cycles form one run at the start of the period, A cycles long.
- R3: Alignment code 1 (right) gives the same period length P. The single run of A active cycles ends on the last cycle of the period.
- R4: Alignment code 2 (center) gives a period of 2P cycles. It holds 2A active cycles, placed symmetrically around the period boundary: the first A cycles and the last A cycles. Code 3 behaves as left.
- R5: With dithering off, A equals duty[W-1:1], and the duty LSB has no effect on the output.
- R6: With dithering on and the duty LSB set, consecutive periods alternate between A and A+1 active counts, so each pair of periods totals 2A+1.
- R7: Sign 0 puts the pulse train on `coil_p` and keeps `coil_n` low for the whole period. Sign 1 does the reverse.
- R8: Written settings take effect only from the next period boundary. The period in progress finishes with the settings it started with.
- R9: Duty 0 gives a constant low output. The all-ones duty gives an output that is active on every cycle of the period, in every alignment mode.
- R10: While `tick` is low, the timers hold, the coil outputs stay constant, and no new period start is signalled.
- R11: `period_start[c]` pulses for one cycle on the first output cycle of each period of channel c.
- R12: A write whose `wr_sel` is 1 changes only channel 1, and a write whose `wr_sel` is 0 changes only channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaler enable; each timer steps only when it is high |
| wr_en | input | 1 | Writes the shadow settings of the selected channel |
| wr_sel | input | 1 | Channel select: 0 for the sine coil, 1 for the cosine coil |
| wr_duty | input | W | Duty word (W = 11 by default) |
| wr_sign | input | 1 | 0: pulse on coil_p; 1: pulse on coil_n |
| wr_align | input | 2 | 0 left, 1 right, 2 center, 3 as left |
| wr_dither | input | 1 | Enables LSB dithering over alternate periods |
| coil_p | output | 2 | Driver A of each H-bridge, index = channel |
| coil_n | output | 2 | Driver B of each H-bridge, index = channel |
| period_start | output | 2 | One-cycle marker on the first output cycle of each period |

## Verification
Some rules are checked on every cycle. The timer freezes whenever `tick` is low. The falling state is only ever entered in center mode. The settings in use change only at a wrap. The unselected driver stays low while the sign selects the other side. Duty 0 gives a low output and the all-ones duty gives an active output. Other properties depend on a whole period, and only the bench scenarios can show them. These are the position and length of the active run in each mode, the center symmetry, the alternation of dither widths, and the one-period delay after a write.

// File: rtl/pwm_motor_pkg.sv
package pwm_motor_pkg;

    // Alignment codes written through wr_align
    localparam logic [1:0] AL_LEFT   = 2'd0;
    localparam logic [1:0] AL_RIGHT  = 2'd1;
    localparam logic [1:0] AL_CENTER = 2'd2;

    // Period timer states
    typedef enum logic {
        T_UP   = 1'b0,
        T_DOWN = 1'b1
    } tstate_e;

endpackage

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_motor_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             center,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] TOP = '1;

    tstate_e          st, st_nx;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        wrap   = 1'b0;
        if (tick) begin
            unique case (st)
                T_UP: begin
                    if (cnt == TOP) begin
                        if (center) begin
                            st_nx = T_DOWN;
                        end else begin
                            cnt_nx = '0;
                            wrap   = 1'b1;
                        end
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                T_DOWN: begin
                    if (cnt == '0) begin
                        st_nx = T_UP;
                        wrap  = 1'b1;
                    end else begin
                        cnt_nx = cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= T_UP;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && $stable(st)));                            // R10

    AST_DOWN_IN_CENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_DOWN) |-> center);                                          // R4

endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
    import pwm_motor_pkg::*;
#(
    parameter int DUTY_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld_en,
    input  logic [DUTY_W-1:0] ld_duty,
    input  logic              ld_sign,
    input  logic [1:0]        ld_align,
    input  logic              ld_dither,
    output logic              drv_p,
    output logic              drv_n,
    output logic              period_start
);

    localparam int              CNT_W = DUTY_W - 1;
    localparam logic [CNT_W:0]  PER   = (CNT_W+1)'(1) << CNT_W;

    logic [DUTY_W-1:0] sh_duty, act_duty;
    logic              sh_sign, act_sign;
    logic [1:0]        sh_align, act_align;
    logic              sh_dith, act_dith;
    logic              odd;
    logic              ps1;

    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic [CNT_W:0]    act_len;
    logic [CNT_W:0]    cnt_x;
    logic              extra;
    logic              pwm_now;

    pwm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .center (act_align == AL_CENTER),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    // Shadow settings, written at any time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_duty  <= '0;
            sh_sign  <= 1'b0;
            sh_align <= AL_LEFT;
            sh_dith  <= 1'b0;
        end else if (ld_en) begin
            sh_duty  <= ld_duty;
            sh_sign  <= ld_sign;
            sh_align <= ld_align;
            sh_dith  <= ld_dither;
        end
    end

    // Settings in use, taken over only at a period boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_duty  <= '0;
            act_sign  <= 1'b0;
            act_align <= AL_LEFT;
            act_dith  <= 1'b0;
            odd       <= 1'b0;
        end else if (wrap) begin
            act_duty  <= sh_duty;
            act_sign  <= sh_sign;
            act_align <= sh_align;
            act_dith  <= sh_dith;
            odd       <= ~odd;
        end
    end

    // Active length in counts
    always_comb begin
        extra = act_dith & act_duty[0] & odd;
        cnt_x = {1'b0, cnt};
        if (&act_duty) begin
            act_len = PER;
        end else begin
            act_len = {1'b0, act_duty[DUTY_W-1:1]} + {{CNT_W{1'b0}}, extra};
        end
        case (act_align)
            AL_RIGHT: pwm_now = (cnt_x >= (PER - act_len));
            default:  pwm_now = (cnt_x < act_len);
        endcase
    end

    // Registered, sign-routed outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_p        <= 1'b0;
            drv_n        <= 1'b0;
            ps1          <= 1'b0;
            period_start <= 1'b0;
        end else begin
            drv_p        <= pwm_now & ~act_sign;
            drv_n        <= pwm_now & act_sign;
            ps1          <= wrap;
            period_start <= ps1;
        end
    end

    AST_SETTINGS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(act_duty) && $stable(act_sign) && $stable(act_align))); // R8

    AST_IDLE_SIDE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        act_sign |=> !drv_p);                                                // R7

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_duty == '0) |=> !(drv_p || drv_n));                             // R9

    AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (&act_duty) |=> (drv_p || drv_n));                                   // R9

endmodule

// File: rtl/stepper_pwm_pair.sv
module stepper_pwm_pair
    import pwm_motor_pkg::*;
#(
    parameter int DUTY_W = 11,
    parameter int N_COIL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DUTY_W-1:0] wr_duty,
    input  logic              wr_sign,
    input  logic [1:0]        wr_align,
    input  logic              wr_dither,
    output logic [N_COIL-1:0] coil_p,
    output logic [N_COIL-1:0] coil_n,
    output logic [N_COIL-1:0] period_start
);

    for (genvar ch = 0; ch < N_COIL; ch++) begin : g_coil
        logic ld_here;
        assign ld_here = wr_en && (wr_sel == 1'(ch));

        pwm_slice #(.DUTY_W(DUTY_W)) u_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .tick         (tick),
            .ld_en        (ld_here),
            .ld_duty      (wr_duty),
            .ld_sign      (wr_sign),
            .ld_align     (wr_align),
            .ld_dither    (wr_dither),
            .drv_p        (coil_p[ch]),
            .drv_n        (coil_n[ch]),
            .period_start (period_start[ch])
        );
    end

endmodule

// File: tb/tb_stepper_pwm_pair.sv
module tb_stepper_pwm_pair;

    localparam int W    = 7;
    localparam int P    = 1 << (W - 1);
    localparam int MAXD = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b1;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_duty = '0;
    logic         wr_sign = 1'b0;
    logic [1:0]   wr_align = 2'd0;
    logic         wr_dither = 1'b0;
    logic [1:0]   coil_p, coil_n, period_start;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    stepper_pwm_pair #(.DUTY_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_duty(wr_duty), .wr_sign(wr_sign),
        .wr_align(wr_align), .wr_dither(wr_dither),
        .coil_p(coil_p), .coil_n(coil_n), .period_start(period_start)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int duty);
        return (duty == MAXD) ? P : (duty >> 1);
    endfunction

    task automatic write_now(input int ch, input int duty, input bit sign,
                             input int align, input bit dith);
        wr_sel = ch[0]; wr_duty = duty[W-1:0]; wr_sign = sign;
        wr_align = align[1:0]; wr_dither = dith; wr_en = 1'b1;
    endtask

    task automatic sync(input int ch);
        do @(negedge clk); while (!period_start[ch]);
    endtask

    // Called at the negedge where period_start[ch] is seen; returns at the next one
    task automatic run_period(input int ch, output int len, output int cp, output int cn,
                              output int first, output int last);
        len = 0; cp = 0; cn = 0; first = -1; last = -1;
        while (1) begin
            if (coil_p[ch]) cp++;
            if (coil_n[ch]) cn++;
            if (coil_p[ch] || coil_n[ch]) begin
                if (first < 0) first = len;
                last = len;
            end
            len++;
            @(negedge clk);
            wr_en = 1'b0;
            if (period_start[ch]) break;
        end
    endtask

    task automatic check_shape(input string req, input int ch, input int duty,
                               input bit sign, input int align);
        int len, cp, cn, first, last, a, on_side, off_side;
        run_period(ch, len, cp, cn, first, last);
        a = exp_len(duty);
        on_side  = sign ? cn : cp;
        off_side = sign ? cp : cn;
        check_eq({req, " R7 idle side"}, off_side, 0);
        if (align == 2) begin
            check_eq({req, " R4 center len"}, len, 2 * P);
            check_eq({req, " R4 center count"}, on_side, 2 * a);
            if (a > 0 && a < P) begin
                check_eq({req, " R4 first"}, first, 0);
                check_eq({req, " R4 last"}, last, 2 * P - 1);
            end
        end else begin
            check_eq({req, " R11 period len"}, len, P);
            check_eq({req, " count"}, on_side, a);
            if (a > 0) begin
                check_eq({req, " contiguous"}, last - first + 1, a);
                if (align == 1) check_eq({req, " R3 ends at last"}, last, P - 1);
                else            check_eq({req, " R2 starts at 0"}, first, 0);
            end
        end
    endtask

    task automatic program_and_check(input string req, input int ch, input int duty,
                                     input bit sign, input int align);
        int len, cp, cn, first, last;
        sync(ch);
        write_now(ch, duty, sign, align, 1'b0);
        run_period(ch, len, cp, cn, first, last);
        check_shape(req, ch, duty, sign, align);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int len, cp, cn, first, last, w1, w2, cur, bad;
        logic [1:0] ref_p, ref_n;
        void'($urandom(32'h5eed));

        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1 outputs in reset", int'({coil_p, coil_n}), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check_eq("R1 outputs after reset", int'({coil_p, coil_n}), 0);
        sync(0);
        run_period(0, len, cp, cn, first, last);
        check_eq("R1 default period len", len, P);
        check_eq("R1 default duty zero", cp + cn, 0);

        // R2 / R3 / R4 / R7 directed
        program_and_check("R2 left", 0, 41, 1'b0, 0);
        program_and_check("R3 right", 0, 50, 1'b0, 1);
        program_and_check("R4 center", 0, 30, 1'b0, 2);
        program_and_check("R4 code3 as left", 0, 22, 1'b0, 3);
        program_and_check("R7 sign1", 0, 60, 1'b1, 0);

        // R9: zero and full scale in each mode
        program_and_check("R9 zero", 0, 0, 1'b0, 1);
        program_and_check("R9 full left", 0, MAXD, 1'b0, 0);
        program_and_check("R9 full right", 0, MAXD, 1'b1, 1);
        program_and_check("R9 full center", 0, MAXD, 1'b0, 2);

        // R5: LSB ignored without dither
        program_and_check("R5 duty1", 0, 1, 1'b0, 0);
        program_and_check("R5 odd duty", 0, 41, 1'b0, 0);
        run_period(0, len, cp, cn, first, last);
        check_eq("R5 odd duty second period", cp, 20);

        // R6: dither alternates
        sync(0);
        write_now(0, 41, 1'b0, 0, 1'b1);
        run_period(0, len, cp, cn, first, last);
        run_period(0, len, w1, cn, first, last);
        run_period(0, len, w2, cn, first, last);
        check_eq("R6 pair sum", w1 + w2, 41);
        check_eq("R6 width step", (w1 > w2) ? w1 - w2 : w2 - w1, 1);
        run_period(0, len, cp, cn, first, last);
        check_eq("R6 third equals first", cp, w1);

        // R8: current period keeps old settings
        program_and_check("R8 setup", 0, 20, 1'b0, 0);
        write_now(0, 90, 1'b0, 0, 1'b0);
        run_period(0, len, cp, cn, first, last);
        check_eq("R8 old period count", cp, 10);
        run_period(0, len, cp, cn, first, last);
        check_eq("R8 new period count", cp, 45);

        // R12: writing channel 1 leaves channel 0 alone
        write_now(1, 100, 1'b1, 2, 1'b0);
        run_period(0, len, cp, cn, first, last);
        run_period(0, len, cp, cn, first, last);
        check_eq("R12 ch0 untouched", cp, 45);
        check_eq("R12 ch0 len untouched", len, P);
        sync(1);
        check_shape("R12 ch1 center", 1, 100, 1'b1, 2);

        // R10: tick low freezes everything
        @(negedge clk);
        tick = 1'b0;
        repeat (3) @(negedge clk);
        ref_p = coil_p; ref_n = coil_n;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (coil_p != ref_p || coil_n != ref_n || period_start != 2'b00) bad++;
        end
        check_eq("R10 frozen while tick low", bad, 0);
        tick = 1'b1;

        // Random mix
        for (int k = 0; k < 12; k++) begin
            cur = $urandom_range(0, MAXD);
            program_and_check("R2 R3 R4 random", $urandom_range(0, 1), cur,
                              1'($urandom_range(0, 1)), $urandom_range(0, 2));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule